// File: doc/BRIEF.md
# Teletext Bit Request and Insertion Scheduler

This block decides when teletext data may enter a composite video line and paces the exchange with an external bit source. Every horizontal sync leading edge advances a line count. A change of the field flag restarts the count at line 1. When the count lies inside the inclusive line range programmed for the current field, the block waits a programmable number of pixel clocks and then opens an insertion window.

While the window is open, a phase accumulator produces bit slots at the average rate of the selected teletext standard. Each slot raises a one-cycle request pulse, and the external source answers each pulse with one bit. The block samples the returned bit after a programmable return delay, which absorbs the source's pipeline latency. It then presents the bit with a one-cycle valid strobe. The window closes by itself once the standard's bit count has been requested. The request start offset is set so that the inserted data lands at the position the video standard requires after the sync edge. Interpolation and analog mixing happen downstream.

Top module: `ttx_inserter`

## Requirements
- R1: During and directly after reset, `ttx_req`, `win_active`, `bit_out` and `bit_vld` are all 0.
- R2: The first `hs_stb` after `field_odd` differs from its value at the previous `hs_stb` sets the line count to 1. Every other `hs_stb` adds 1 to the line count. A window may open on a line only if its count lies within the inclusive range of the active field: `cfg_odd_first`..`cfg_odd_last` when `field_odd`=1, and `cfg_even_first`..`cfg_even_last` otherwise.
- R3: A line whose `hs_stb` sees `cfg_en`=0 opens no window and issues no request.
- R4: Call the `hs_stb` clock edge edge 0, and let S be `cfg_req_start`. On an enabled, in-range line, `win_active` goes high after edge S+1.
- R5: The accumulator is cleared when the window opens and adds the standard's increment on every following clock, modulo 2^ACC_W. Each carry out is a bit slot and produces a `ttx_req` pulse of exactly one cycle. `cfg_std` codes are: 0 = 625-line standard, 1 = world-standard 525-line, 2 = North American broadcast standard, and 3 is treated as 2.
- R6: Each window issues exactly the standard's bit count of requests. The window closes at the first slot after the last request. `ttx_req` is never high while `win_active` is low.
- R7: Let d be `cfg_ret_dly`. `ttx_din` is sampled at the (d+1)-th rising edge after the edge that raised a request. The sample appears on `bit_out`, and `bit_vld` is high for that one cycle.
- R8: A bit whose sample edge comes after the window has closed is discarded, and `bit_vld` stays low.
- R9: If `cfg_en` falls during a window, the window closes at the next bit slot. No further request is issued, and bits not yet sampled are discarded.
- R10: `cfg_std`, `cfg_req_start`, `cfg_ret_dly` and the line ranges are captured only at `hs_stb`. Changing them in mid-line affects only later lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_stb | input | 1 | One-cycle strobe at the horizontal sync leading edge |
| field_odd | input | 1 | 1 in the odd field, 0 in the even field |
| cfg_en | input | 1 | Teletext insertion enable |
| cfg_std | input | 2 | Standard select (see R5) |
| cfg_req_start | input | START_W | Clocks from sync edge to window opening |
| cfg_ret_dly | input | DLY_W | Return delay of the bit source, minus one clock |
| cfg_odd_first | input | LINE_W | First insertion line, odd field |
| cfg_odd_last | input | LINE_W | Last insertion line, odd field |
| cfg_even_first | input | LINE_W | First insertion line, even field |
| cfg_even_last | input | LINE_W | Last insertion line, even field |
| ttx_din | input | 1 | Serial bit returned by the source |
| ttx_req | output | 1 | One-cycle request for the next bit |
| win_active | output | 1 | Insertion window open |
| bit_out | output | 1 | Latest sampled teletext bit |
| bit_vld | output | 1 | One-cycle strobe marking a new `bit_out` |

## Verification
The bench builds the block with an 8-bit accumulator, increments of 128, 80 and 96, bit counts of 12, 8 and 6, a 2-bit return delay and 6-bit line numbers. A whole window then lasts only a few dozen clocks, so every standard code, a range of start offsets and every return delay can be swept line by line. The increments of 80 and 96 give uneven slot spacing, which exercises the carry arithmetic. At the larger delays, the final bits outlive the window, which reaches the discard rule. Field toggles, narrow line ranges, mid-line disables and mid-line configuration changes are compared cycle by cycle against a closed-form model of slot positions.

// File: rtl/ttx_pkg.sv
// Package: shared encodings for the teletext scheduler.
// Assumes: cfg_std is two bits wide; code 3 is folded onto code 2 by users.
package ttx_pkg;

    typedef enum logic [1:0] {
        STD_625   = 2'd0,
        STD_WORLD = 2'd1,
        STD_NA    = 2'd2,
        STD_RSVD  = 2'd3
    } ttx_std_e;

    typedef enum logic [1:0] {
        WIN_IDLE = 2'd0,
        WIN_WAIT = 2'd1,
        WIN_RUN  = 2'd2
    } win_state_e;

endpackage

// File: rtl/ttx_line_track.sv
// Module: line and field tracker.
// Counts sync edges within a field. It flags, in the strobe cycle itself, whether
// the line that starts now is enabled and inside the active field's range.
// Assumes: hs_stb is a single-cycle pulse. Ranges are inclusive and read only at hs_stb.
module ttx_line_track #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_stb,
    input  logic              field_odd,
    input  logic              cfg_en,
    input  logic [LINE_W-1:0] cfg_odd_first,
    input  logic [LINE_W-1:0] cfg_odd_last,
    input  logic [LINE_W-1:0] cfg_even_first,
    input  logic [LINE_W-1:0] cfg_even_last,
    output logic              line_hit
);

    logic              last_field;
    logic [LINE_W-1:0] line_cnt;
    logic [LINE_W-1:0] line_nxt;
    logic [LINE_W-1:0] rng_lo;
    logic [LINE_W-1:0] rng_hi;

    // Next line number: restart at 1 when the field flag changed.
    always_comb begin
        line_nxt = (field_odd != last_field) ? LINE_W'(1) : line_cnt + LINE_W'(1);
        rng_lo   = field_odd ? cfg_odd_first : cfg_even_first;
        rng_hi   = field_odd ? cfg_odd_last  : cfg_even_last;
        line_hit = hs_stb && cfg_en && (line_nxt >= rng_lo) && (line_nxt <= rng_hi);
    end

    // Register the line number and field at each sync edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_field <= 1'b0;
            line_cnt   <= '0;
        end else if (hs_stb) begin
            last_field <= field_odd;
            line_cnt   <= line_nxt;
        end
    end

endmodule

// File: rtl/ttx_bit_clock.sv
// Module: phase-accumulator bit slot generator.
// Emits a slot on every carry out of an ACC_W-bit accumulator that adds the
// increment of the latched standard once per clock while running.
// Assumes: every increment is at most 2^(ACC_W-1), so slots are never adjacent.
module ttx_bit_clock #(
    parameter int ACC_W     = 16,
    parameter int INC_625   = 16839,
    parameter int INC_WORLD = 13901,
    parameter int INC_NA    = 13901
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       run,
    input  logic [1:0] std_sel,
    output logic       slot
);
    import ttx_pkg::*;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] inc;
    logic [ACC_W:0]   sum;

    // Pick the increment for the latched standard.
    always_comb begin
        case (ttx_std_e'(std_sel))
            STD_625:   inc = ACC_W'(INC_625);
            STD_WORLD: inc = ACC_W'(INC_WORLD);
            default:   inc = ACC_W'(INC_NA);
        endcase
        sum  = {1'b0, acc} + {1'b0, inc};
        slot = run && sum[ACC_W];
    end

    // Accumulate phase while the window runs; restart from zero at opening.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc <= '0;
        else if (clear) acc <= '0;
        else if (run)   acc <= sum[ACC_W-1:0];
    end

endmodule

// File: rtl/ttx_req_gen.sv
// Module: window sequencer and request generator.
// Waits the start offset after an accepted sync edge, then runs the window. It
// raises one request per slot until the bit count is met, and closes the window
// at the following slot or at the first slot seen with the enable low.
// Assumes: line_hit is valid only in the hs_stb cycle.
module ttx_req_gen #(
    parameter int START_W   = 10,
    parameter int CNT_W     = 9,
    parameter int BITS_625  = 360,
    parameter int BITS_WRLD = 296,
    parameter int BITS_NA   = 288
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hs_stb,
    input  logic               line_hit,
    input  logic [START_W-1:0] cfg_req_start,
    input  logic [1:0]         cfg_std,
    input  logic               cfg_en,
    input  logic               slot,
    output logic [1:0]         std_q,
    output logic               open_now,
    output logic               running,
    output logic               ttx_req
);
    import ttx_pkg::*;

    win_state_e         state;
    logic [START_W-1:0] wait_cnt;
    logic [CNT_W-1:0]   bit_cnt;
    logic [CNT_W-1:0]   bit_lim;

    // Bit budget of the latched standard, plus decoded state flags.
    always_comb begin
        case (ttx_std_e'(std_q))
            STD_625:   bit_lim = CNT_W'(BITS_625);
            STD_WORLD: bit_lim = CNT_W'(BITS_WRLD);
            default:   bit_lim = CNT_W'(BITS_NA);
        endcase
        running  = (state == WIN_RUN);
        open_now = !hs_stb && (state == WIN_WAIT) && (wait_cnt == '0);
    end

    // Sequence the line: arm at sync, count the offset, request per slot, close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= WIN_IDLE;
            wait_cnt <= '0;
            bit_cnt  <= '0;
            std_q    <= 2'd0;
            ttx_req  <= 1'b0;
        end else begin
            ttx_req <= 1'b0;
            if (hs_stb) begin
                std_q    <= cfg_std;
                wait_cnt <= cfg_req_start;
                bit_cnt  <= '0;
                state    <= line_hit ? WIN_WAIT : WIN_IDLE;
            end else begin
                case (state)
                    WIN_WAIT: begin
                        if (wait_cnt == '0) state <= WIN_RUN;
                        else                wait_cnt <= wait_cnt - 1'b1;
                    end
                    WIN_RUN: begin
                        if (slot) begin
                            if (!cfg_en || bit_cnt == bit_lim) begin
                                state <= WIN_IDLE;
                            end else begin
                                ttx_req <= 1'b1;
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    default: state <= WIN_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/ttx_bit_return.sv
// Module: return-delay sampler.
// Delays the request pulse through a tapped shift line. It samples the serial
// input when the tap chosen at the last sync edge fires, if the window is still open.
// Assumes: DLY_W >= 1; the delay value is read only at hs_stb.
module ttx_bit_return #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_stb,
    input  logic [DLY_W-1:0] cfg_ret_dly,
    input  logic             req,
    input  logic             running,
    input  logic             din,
    output logic             bit_out,
    output logic             bit_vld
);
    localparam int TAPS = 2 ** DLY_W;

    logic [DLY_W-1:0] dly_q;
    logic [TAPS-2:0]  pipe;
    logic [TAPS-1:0]  taps;
    logic             fire;

    // Shift line for the request pulse; width follows the delay field.
    generate
        if (TAPS == 2) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= req;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[TAPS-3:0], req};
            end
        end
    endgenerate

    // Select the tap of the latched delay.
    always_comb begin
        taps = {pipe, req};
        fire = taps[dly_q];
    end

    // Latch the delay per line and capture bits that return inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q   <= '0;
            bit_out <= 1'b0;
            bit_vld <= 1'b0;
        end else begin
            if (hs_stb) dly_q <= cfg_ret_dly;
            bit_vld <= fire && running;
            if (fire && running) bit_out <= din;
        end
    end

endmodule

// File: rtl/ttx_inserter.sv
// Module: teletext bit request and insertion scheduler (top).
// Ties together the line tracker, window sequencer, slot generator and return sampler.
// Assumes: one clock domain; hs_stb is a single-cycle pulse per line.
module ttx_inserter #(
    parameter int LINE_W    = 10,
    parameter int START_W   = 10,
    parameter int DLY_W     = 4,
    parameter int ACC_W     = 16,
    parameter int INC_625   = 16839,
    parameter int INC_WORLD = 13901,
    parameter int INC_NA    = 13901,
    parameter int BITS_625  = 360,
    parameter int BITS_WRLD = 296,
    parameter int BITS_NA   = 288
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hs_stb,
    input  logic               field_odd,
    input  logic               cfg_en,
    input  logic [1:0]         cfg_std,
    input  logic [START_W-1:0] cfg_req_start,
    input  logic [DLY_W-1:0]   cfg_ret_dly,
    input  logic [LINE_W-1:0]  cfg_odd_first,
    input  logic [LINE_W-1:0]  cfg_odd_last,
    input  logic [LINE_W-1:0]  cfg_even_first,
    input  logic [LINE_W-1:0]  cfg_even_last,
    input  logic               ttx_din,
    output logic               ttx_req,
    output logic               win_active,
    output logic               bit_out,
    output logic               bit_vld
);
    localparam int MAX_BITS = (BITS_625 > BITS_WRLD)
                            ? ((BITS_625 > BITS_NA) ? BITS_625 : BITS_NA)
                            : ((BITS_WRLD > BITS_NA) ? BITS_WRLD : BITS_NA);
    localparam int CNT_W    = $clog2(MAX_BITS + 2);

    logic       line_hit;
    logic       slot;
    logic       open_now;
    logic       running;
    logic [1:0] std_q;

    ttx_line_track #(.LINE_W(LINE_W)) u_track (
        .clk(clk), .rst_n(rst_n), .hs_stb(hs_stb), .field_odd(field_odd),
        .cfg_en(cfg_en),
        .cfg_odd_first(cfg_odd_first), .cfg_odd_last(cfg_odd_last),
        .cfg_even_first(cfg_even_first), .cfg_even_last(cfg_even_last),
        .line_hit(line_hit)
    );

    ttx_req_gen #(
        .START_W(START_W), .CNT_W(CNT_W),
        .BITS_625(BITS_625), .BITS_WRLD(BITS_WRLD), .BITS_NA(BITS_NA)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .hs_stb(hs_stb), .line_hit(line_hit),
        .cfg_req_start(cfg_req_start), .cfg_std(cfg_std), .cfg_en(cfg_en),
        .slot(slot), .std_q(std_q), .open_now(open_now), .running(running),
        .ttx_req(ttx_req)
    );

    ttx_bit_clock #(
        .ACC_W(ACC_W), .INC_625(INC_625), .INC_WORLD(INC_WORLD), .INC_NA(INC_NA)
    ) u_clk (
        .clk(clk), .rst_n(rst_n), .clear(open_now), .run(running),
        .std_sel(std_q), .slot(slot)
    );

    ttx_bit_return #(.DLY_W(DLY_W)) u_ret (
        .clk(clk), .rst_n(rst_n), .hs_stb(hs_stb), .cfg_ret_dly(cfg_ret_dly),
        .req(ttx_req), .running(running), .din(ttx_din),
        .bit_out(bit_out), .bit_vld(bit_vld)
    );

    assign win_active = running;

endmodule

// File: rtl/ttx_inserter_chk.sv
// Module: protocol checker bound to the scheduler top.
// Observes only top-level ports. It keeps its own per-line request counter.
// Assumes: rst_n is synchronous and active low.
module ttx_inserter_chk #(
    parameter int MAX_BITS = 360
) (
    input logic clk,
    input logic rst_n,
    input logic hs_stb,
    input logic cfg_en,
    input logic ttx_req,
    input logic win_active,
    input logic bit_vld
);
    localparam int CW = $clog2(MAX_BITS + 2);

    logic [CW-1:0] req_seen;

    // Count requests issued since the last sync edge.
    always_ff @(posedge clk) begin
        if (!rst_n || hs_stb) req_seen <= '0;
        else if (ttx_req)     req_seen <= req_seen + 1'b1;
    end

    // R6
    req_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ttx_req |-> win_active);

    // R5
    req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ttx_req |=> !ttx_req);

    // R8
    vld_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> $past(win_active));

    // R3
    disabled_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_stb && !cfg_en) |=> !win_active);

    // R6
    req_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_seen <= CW'(MAX_BITS));

endmodule

bind ttx_inserter ttx_inserter_chk #(.MAX_BITS(MAX_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .hs_stb(hs_stb), .cfg_en(cfg_en),
    .ttx_req(ttx_req), .win_active(win_active), .bit_vld(bit_vld)
);

// File: tb/ttx_inserter_tb.sv
`timescale 1ns/1ps
// Bench: line-by-line sweep of the teletext scheduler against a closed-form slot model.
module ttx_inserter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs_stb = 1'b0;
    logic       field_odd = 1'b0;
    logic       cfg_en = 1'b0;
    logic [1:0] cfg_std = 2'd0;
    logic [3:0] cfg_req_start = '0;
    logic [1:0] cfg_ret_dly = '0;
    logic [5:0] cfg_odd_first = '0, cfg_odd_last = '0;
    logic [5:0] cfg_even_first = '0, cfg_even_last = '0;
    logic       ttx_din = 1'b0;
    logic       ttx_req, win_active, bit_out, bit_vld;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int g_of, g_ol, g_ef, g_el;
    bit bm_last = 1'b0;
    int bm_cnt = 0;

    always #2.5 clk = ~clk;

    ttx_inserter #(
        .LINE_W(6), .START_W(4), .DLY_W(2), .ACC_W(8),
        .INC_625(128), .INC_WORLD(80), .INC_NA(96),
        .BITS_625(12), .BITS_WRLD(8), .BITS_NA(6)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .hs_stb(hs_stb), .field_odd(field_odd),
        .cfg_en(cfg_en), .cfg_std(cfg_std), .cfg_req_start(cfg_req_start),
        .cfg_ret_dly(cfg_ret_dly),
        .cfg_odd_first(cfg_odd_first), .cfg_odd_last(cfg_odd_last),
        .cfg_even_first(cfg_even_first), .cfg_even_last(cfg_even_last),
        .ttx_din(ttx_din), .ttx_req(ttx_req), .win_active(win_active),
        .bit_out(bit_out), .bit_vld(bit_vld)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic bit carry_at(input int j, input int inc);
        return (j >= 1) && (((j * inc) >> 8) != (((j - 1) * inc) >> 8));
    endfunction

    function automatic bit pat(input int c);
        return 1'(((c * 13) >> 2) & 1);
    endfunction

    // One video line: sync strobe, then a cycle-by-cycle comparison with the model.
    task automatic run_line(input bit fld, input bit en, input int std, input int s,
                            input int d, input int kill_at, input bit scr, input string tag);
        int inc, n, nxt, lo, hi, endc, span, nr, nv, er_cnt, ev_cnt;
        bit hit, ew, er, ev;
        inc = (std == 0) ? 128 : (std == 1) ? 80 : 96;
        n   = (std == 0) ? 12  : (std == 1) ? 8  : 6;
        nxt = (fld != bm_last) ? 1 : bm_cnt + 1;
        bm_last = fld;
        bm_cnt  = nxt;
        lo  = fld ? g_of : g_ef;
        hi  = fld ? g_ol : g_el;
        hit = en && nxt >= lo && nxt <= hi;
        span = ((n + 1) * 256 + inc - 1) / inc;
        endc = s + 1 + span;
        if (kill_at > 0)
            for (int c = kill_at; c < s + 1 + span; c++)
                if (c >= s + 2 && carry_at(c - s - 1, inc)) begin endc = c; break; end
        hs_stb = 1'b1; field_odd = fld; cfg_en = en; cfg_std = 2'(std);
        cfg_req_start = 4'(s); cfg_ret_dly = 2'(d);
        cfg_odd_first = 6'(g_of); cfg_odd_last = 6'(g_ol);
        cfg_even_first = 6'(g_ef); cfg_even_last = 6'(g_el);
        @(posedge clk); @(negedge clk);
        hs_stb = 1'b0;
        nr = 0; nv = 0; er_cnt = 0; ev_cnt = 0;
        for (int c = 1; c <= s + span + 12; c++) begin
            ttx_din = pat(c);
            if (kill_at > 0 && c >= kill_at) cfg_en = 1'b0;
            if (scr && c == 2) begin
                cfg_std = 2'(std ^ 1); cfg_req_start = 4'(s + 5); cfg_ret_dly = 2'(d ^ 1);
                cfg_odd_first = '0; cfg_odd_last = '0; cfg_even_first = '0; cfg_even_last = '0;
            end
            @(posedge clk); @(negedge clk);
            ew = hit && c >= s + 1 && c < endc;
            er = hit && c >= s + 2 && c < endc && carry_at(c - s - 1, inc);
            ev = hit && c <= endc && (c - 1 - d) >= s + 2 && (c - 1 - d) < endc
                 && carry_at(c - 1 - d - s - 1, inc);
            if (er) er_cnt++;
            if (ev) ev_cnt++;
            if (ttx_req) nr++;
            if (bit_vld) nv++;
            // R4 window timing (R2/R3/R9 gate it)
            check(win_active == ew, "R4 win_active", win_active, ew);
            // R5 request per slot
            check(ttx_req == er, "R5 ttx_req", ttx_req, er);
            // R7 sample strobe (R8 discard)
            check(bit_vld == ev, "R7 bit_vld", bit_vld, ev);
            if (ev) check(bit_out == pat(c), "R7 bit_out", bit_out, pat(c));
        end
        // line totals under the caller's requirement
        check(nr == ((hit && kill_at == 0) ? n : er_cnt), {tag, " request total"}, nr,
              (hit && kill_at == 0) ? n : er_cnt);
        check(nv == ev_cnt, {tag, " valid total"}, nv, ev_cnt);
    endtask

    initial begin : watchdog
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 outputs quiet in reset
        check({ttx_req, win_active, bit_out, bit_vld} == 4'b0, "R1 reset outputs",
              {ttx_req, win_active, bit_out, bit_vld}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({ttx_req, win_active, bit_out, bit_vld} == 4'b0, "R1 after reset",
              {ttx_req, win_active, bit_out, bit_vld}, 0);

        // R2 line ranges per field
        g_of = 2; g_ol = 3; g_ef = 1; g_el = 2;
        for (int l = 0; l < 5; l++) run_line(1'b1, 1'b1, 0, 1, 0, 0, 1'b0, "R2");
        for (int l = 0; l < 4; l++) run_line(1'b0, 1'b1, 0, 1, 0, 0, 1'b0, "R2");
        run_line(1'b1, 1'b1, 2, 0, 1, 0, 1'b0, "R2");

        // R6 sweep of standards, offsets and delays (R8 at long delays)
        g_of = 1; g_ol = 60; g_ef = 1; g_el = 60;
        run_line(1'b0, 1'b1, 0, 0, 0, 0, 1'b0, "R6");
        for (int sd = 0; sd < 4; sd++)
            for (int si = 0; si < 3; si++)
                for (int dd = 0; dd < 4; dd++)
                    run_line(1'b1, 1'b1, sd, si * si + si, dd, 0, 1'b0, "R6");
        run_line(1'b1, 1'b1, 0, 2, 3, 0, 1'b0, "R8");

        // R3 disabled lines
        run_line(1'b1, 1'b0, 0, 1, 0, 0, 1'b0, "R3");
        run_line(1'b1, 1'b0, 1, 0, 2, 0, 1'b0, "R3");

        // R9 mid-line disable at several points
        for (int k = 3; k < 20; k += 4) run_line(1'b0, 1'b1, 0, 1, 1, k, 1'b0, "R9");
        run_line(1'b0, 1'b1, 2, 3, 3, 9, 1'b0, "R9");

        // R10 mid-line configuration changes ignored until next line
        run_line(1'b1, 1'b1, 1, 2, 1, 0, 1'b1, "R10");
        run_line(1'b1, 1'b1, 0, 0, 2, 0, 1'b1, "R10");
        run_line(1'b1, 1'b1, 2, 4, 0, 0, 1'b0, "R10");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule